// File: doc/BRIEF.md
# Byte Register Bus Slave

This block is a slave on a 32-bit asynchronous-style system bus that offers five byte-wide registers. These are transmit data, transmit control/status, receive data, receive control/status, and serial control. A master starts an access by pulling the active-low select and the active-low address strobe low. The slave decodes the register address and the size code and performs the read or write. It then reports completion by pulling only the byte-acknowledge line low. Byte data always travels on the top lane of the data bus, bits 31:24. When the master raises the strobe, the slave releases the acknowledge.

Behind the bus sit the transmit-enable flag and two status flags. The busy flag is set by a write to transmit data and cleared by the transmitter's done report. The ready flag is set when the receiver delivers a byte and cleared when software reads that byte. Writes to transmit data and to serial control are passed to the link side as one-cycle strobes that carry the byte. The serial line coding itself lies outside the block.

Top module: `byte_reg_slave`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `ack_byte_n`, `ack_lo_n`, `ack_hi_n` and `lerr_n` are high, `rdata` is 0, and `tx_en`, `tx_strobe` and `ser_strobe` are 0.
- R2: When `sel_n` and `as_n` are both low with the slave idle, `ack_byte_n` goes low at the next clock edge (within 2 clocks). `ack_lo_n`, `ack_hi_n` and `lerr_n` stay high at all times.
- R3: One clock edge after `as_n` is seen high, `ack_byte_n` is high again.
- R4: Byte data uses `wdata[31:24]` and `rdata[31:24]`. `rdata[23:0]` is always 0, and all of `rdata` is 0 while `ack_byte_n` is high.
- R5: Register addresses are 0 transmit data, 1 transmit control, 2 receive data, 3 receive control, 4 serial control. A byte access has size code 1, and `rd`=1 selects a read. Writing transmit control copies byte bit 6 to `tx_en`. A read of transmit control returns `tx_en` in bit 6.
- R6: Bit 7 of transmit control reads as busy. It is 0 after reset and 1 after a write to transmit data, and it clears when `tx_done` pulses. Such a write also gives a one-cycle `tx_strobe` with the byte on `tx_byte`. A read of transmit data returns the last byte written.
- R7: An `rx_valid` pulse stores `rx_byte` and sets bit 7 of receive control (ready). A read of receive data returns the stored byte and clears ready. If a receive event and a clear fall in the same cycle, the receive event wins.
- R8: A write to serial control gives a one-cycle `ser_strobe` with the byte on `ser_byte`. A read returns the last value written.
- R9: An access with a size code other than 1, or to an address above 4, is still acknowledged. It returns read data 0 and changes no register, flag or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low slave select |
| as_n | input | 1 | Active-low address strobe |
| siz | input | 3 | Transfer size code, 1 = byte |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data, byte on bits 31:24 |
| rdata | output | 32 | Read data, byte on bits 31:24 |
| ack_lo_n | output | 1 | Unused acknowledge line, held high |
| ack_byte_n | output | 1 | Active-low byte acknowledge |
| ack_hi_n | output | 1 | Unused acknowledge line, held high |
| lerr_n | output | 1 | Late error line, held high |
| tx_en | output | 1 | Transmit enable |
| tx_strobe | output | 1 | One-cycle pulse: new transmit byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_done | input | 1 | Transmitter finished a byte |
| rx_valid | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| ser_strobe | output | 1 | One-cycle pulse: serial control written |
| ser_byte | output | 8 | Serial control byte |

## Verification
Inputs change on the falling clock edge, so the rising edge that follows registers the acknowledge, the read data and every side effect at once. Each of these results is sampled at the next falling edge, one cycle after the stimulus. The release of the acknowledge is sampled one cycle after the strobe is raised. The transmit strobe is due one cycle after the accepting edge, and the bench counts it there. The loopback model answers 20 cycles after the strobe. This leaves room to read busy as set before the done pulse clears it, and the receive ready flag is then polled through the bus until it appears.

// File: rtl/byte_slave_pkg.sv
// Package: shared register codes, size code and handshake state type for
// the byte register bus slave.
package byte_slave_pkg;
    localparam int unsigned REG_TXD  = 0;
    localparam int unsigned REG_TXC  = 1;
    localparam int unsigned REG_RXD  = 2;
    localparam int unsigned REG_RXC  = 3;
    localparam int unsigned REG_SER  = 4;
    localparam int unsigned REG_LAST = REG_SER;
    localparam int unsigned SIZE_BYTE = 1;
    localparam int unsigned TXC_EN_BIT   = 6;
    localparam int unsigned STAT_BIT     = 7;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_t;
endpackage

// File: rtl/bsl_handshake.sv
// Module: bsl_handshake
// Bus-side handshake. Detects the start of an access (select and strobe both
// low while idle), raises a one-cycle accept pulse, holds the active-low byte
// acknowledge until the strobe rises, then raises a release pulse.
// Assumes: the master keeps select and strobe stable while waiting and raises
// the strobe to end the access.
module bsl_handshake
    import byte_slave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic as_n,
    output logic accept,
    output logic release_p,
    output logic ack_n
);
    hs_state_t state;

    // Start and end of an access, decoded from the current state.
    always_comb begin
        accept    = (state == HS_IDLE) && !sel_n && !as_n;
        release_p = (state == HS_ACK) && as_n;
    end

    // State register and registered acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            ack_n <= 1'b1;
        end else if (accept) begin
            state <= HS_ACK;
            ack_n <= 1'b0;
        end else if (release_p) begin
            state <= HS_IDLE;
            ack_n <= 1'b1;
        end
    end
endmodule

// File: rtl/bsl_rdmux.sv
// Module: bsl_rdmux
// Combinational read byte selection from register state.
// Assumes: address validity is judged by the caller; unknown codes give 0.
module bsl_rdmux
    import byte_slave_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned LANE_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] tx_byte,
    input  logic              tx_en,
    input  logic              busy,
    input  logic [LANE_W-1:0] rx_hold,
    input  logic              ready,
    input  logic [LANE_W-1:0] ser_byte,
    output logic [LANE_W-1:0] rd_byte
);
    // Pick the byte returned for the addressed register.
    always_comb begin
        rd_byte = '0;
        case (addr)
            ADDR_W'(REG_TXD): rd_byte = tx_byte;
            ADDR_W'(REG_TXC): begin
                rd_byte[STAT_BIT]   = busy;
                rd_byte[TXC_EN_BIT] = tx_en;
            end
            ADDR_W'(REG_RXD): rd_byte = rx_hold;
            ADDR_W'(REG_RXC): rd_byte[STAT_BIT] = ready;
            ADDR_W'(REG_SER): rd_byte = ser_byte;
            default:          rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/bsl_regs.sv
// Module: bsl_regs
// Register state: transmit enable, busy and ready flags, the held bytes and
// the link strobes. Performs the access on the accept pulse and registers the
// read data, which is cleared again on the release pulse.
// Assumes: accept and release_p never coincide.
module bsl_regs
    import byte_slave_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned SIZ_W  = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              release_p,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZ_W-1:0]  siz,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_en,
    output logic              tx_strobe,
    output logic [LANE_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [LANE_W-1:0] rx_byte,
    output logic              ser_strobe,
    output logic [LANE_W-1:0] ser_byte
);
    localparam int unsigned LOW_W = DATA_W - LANE_W;

    logic              busy;
    logic              ready;
    logic [LANE_W-1:0] rx_hold;
    logic [LANE_W-1:0] wr_byte;
    logic [LANE_W-1:0] rd_byte;
    logic              legal;
    logic              do_wr;
    logic              do_rd;

    // Decode: legal byte access to a known register.
    always_comb begin
        wr_byte = wdata[DATA_W-1 -: LANE_W];
        legal   = (siz == SIZ_W'(SIZE_BYTE)) && (addr <= ADDR_W'(REG_LAST));
        do_wr   = accept && legal && !rd;
        do_rd   = accept && legal && rd;
    end

    bsl_rdmux #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rdmux (
        .addr     (addr),
        .tx_byte  (tx_byte),
        .tx_en    (tx_en),
        .busy     (busy),
        .rx_hold  (rx_hold),
        .ready    (ready),
        .ser_byte (ser_byte),
        .rd_byte  (rd_byte)
    );

    // Transmit side: enable, held byte, strobe and busy flag (write beats done).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en     <= 1'b0;
            tx_byte   <= '0;
            tx_strobe <= 1'b0;
            busy      <= 1'b0;
        end else begin
            tx_strobe <= 1'b0;
            if (tx_done) busy <= 1'b0;
            if (do_wr && addr == ADDR_W'(REG_TXD)) begin
                tx_byte   <= wr_byte;
                tx_strobe <= 1'b1;
                busy      <= 1'b1;
            end
            if (do_wr && addr == ADDR_W'(REG_TXC)) tx_en <= wr_byte[TXC_EN_BIT];
        end
    end

    // Receive side: held byte and ready flag (arrival beats read clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            ready   <= 1'b0;
        end else begin
            if (do_rd && addr == ADDR_W'(REG_RXD)) ready <= 1'b0;
            if (rx_valid) begin
                rx_hold <= rx_byte;
                ready   <= 1'b1;
            end
        end
    end

    // Serial control: held byte and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_byte   <= '0;
            ser_strobe <= 1'b0;
        end else begin
            ser_strobe <= 1'b0;
            if (do_wr && addr == ADDR_W'(REG_SER)) begin
                ser_byte   <= wr_byte;
                ser_strobe <= 1'b1;
            end
        end
    end

    // Read data on the top lane, valid while acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (accept) begin
            rdata <= do_rd ? {rd_byte, {LOW_W{1'b0}}} : '0;
        end else if (release_p) begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/byte_reg_slave.sv
// Module: byte_reg_slave
// Top of the byte register bus slave: handshake plus register state. Only
// the byte acknowledge line is ever driven low; the other completion lines
// and the late error line are tied inactive.
// Assumes: one master, byte data on the top lane of the data bus.
module byte_reg_slave #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned SIZ_W  = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              as_n,
    input  logic [SIZ_W-1:0]  siz,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack_lo_n,
    output logic              ack_byte_n,
    output logic              ack_hi_n,
    output logic              lerr_n,
    output logic              tx_en,
    output logic              tx_strobe,
    output logic [LANE_W-1:0] tx_byte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [LANE_W-1:0] rx_byte,
    output logic              ser_strobe,
    output logic [LANE_W-1:0] ser_byte
);
    logic accept;
    logic release_p;

    // Unused completion and error lines stay inactive.
    always_comb begin
        ack_lo_n = 1'b1;
        ack_hi_n = 1'b1;
        lerr_n   = 1'b1;
    end

    bsl_handshake u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .as_n      (as_n),
        .accept    (accept),
        .release_p (release_p),
        .ack_n     (ack_byte_n)
    );

    bsl_regs #(
        .ADDR_W(ADDR_W), .SIZ_W(SIZ_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .release_p  (release_p),
        .rd         (rd),
        .addr       (addr),
        .siz        (siz),
        .wdata      (wdata),
        .rdata      (rdata),
        .tx_en      (tx_en),
        .tx_strobe  (tx_strobe),
        .tx_byte    (tx_byte),
        .tx_done    (tx_done),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .ser_strobe (ser_strobe),
        .ser_byte   (ser_byte)
    );
endmodule

// File: rtl/bsl_checker.sv
// Module: bsl_checker
// Port-level temporal checks for byte_reg_slave, attached by bind.
module bsl_checker #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned SIZ_W  = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              as_n,
    input logic [DATA_W-1:0] rdata,
    input logic              ack_lo_n,
    input logic              ack_byte_n,
    input logic              ack_hi_n,
    input logic              lerr_n,
    input logic              tx_strobe,
    input logic              ser_strobe
);
    // R2
    side_lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_lo_n && ack_hi_n && lerr_n);
    // R2
    ack_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !as_n && ack_byte_n) |=> !ack_byte_n);
    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> ack_byte_n);
    // R4
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_byte_n |-> (rdata == '0));
    // R4
    low_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-LANE_W-1:0] == '0);
    // R6
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);
    // R8
    ser_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe |=> !ser_strobe);
endmodule

bind byte_reg_slave bsl_checker #(
    .ADDR_W(ADDR_W), .SIZ_W(SIZ_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .as_n       (as_n),
    .rdata      (rdata),
    .ack_lo_n   (ack_lo_n),
    .ack_byte_n (ack_byte_n),
    .ack_hi_n   (ack_hi_n),
    .lerr_n     (lerr_n),
    .tx_strobe  (tx_strobe),
    .ser_strobe (ser_strobe)
);

// File: tb/byte_reg_slave_bench.sv
module byte_reg_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        as_n = 1'b1;
    logic [2:0]  siz = 3'd0;
    logic        rd = 1'b1;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack_lo_n, ack_byte_n, ack_hi_n, lerr_n;
    logic        tx_en, tx_strobe, ser_strobe;
    logic [7:0]  tx_byte, ser_byte;
    logic        tx_done, rx_valid;
    logic [7:0]  rx_byte;

    int tests = 0;
    int fails = 0;
    int tx_cnt = 0;
    int ser_cnt = 0;
    int lb_cnt = 0;
    logic [7:0] lb_byte = '0;

    always #4 clk = ~clk;

    byte_reg_slave u_byte_reg_slave (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .as_n(as_n), .siz(siz),
        .rd(rd), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ack_lo_n(ack_lo_n), .ack_byte_n(ack_byte_n), .ack_hi_n(ack_hi_n),
        .lerr_n(lerr_n), .tx_en(tx_en), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .tx_done(tx_done), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .ser_strobe(ser_strobe), .ser_byte(ser_byte)
    );

    // Loopback link model: 20 cycles after a transmit strobe, report done and
    // deliver the same byte to the receiver.
    assign tx_done  = (lb_cnt == 1);
    assign rx_valid = (lb_cnt == 1);
    assign rx_byte  = lb_byte;
    always @(posedge clk) begin
        if (tx_strobe) begin
            lb_cnt  <= 20;
            lb_byte <= tx_byte;
            tx_cnt  <= tx_cnt + 1;
        end else if (lb_cnt > 0) begin
            lb_cnt <= lb_cnt - 1;
        end
        if (ser_strobe) ser_cnt <= ser_cnt + 1;
    end

    // Watchdog
    initial begin
        #1600000;
        fails = fails + 1;
        $display("FAIL watchdog: run hung (actual running, expected done)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus access; returns the top-lane read byte and checks the handshake.
    task automatic bus(input logic r, input logic [2:0] a, input logic [2:0] s,
                       input logic [7:0] wd, output logic [7:0] got);
        int lat;
        lat = 0;
        rd = r; addr = a; siz = s; wdata = {wd, 24'h0};
        sel_n = 1'b0; as_n = 1'b0;
        for (int i = 0; i < 255; i++) begin
            @(negedge clk);
            lat = lat + 1;
            if (!ack_byte_n) break;
        end
        check("R2 ack latency", 32'(lat <= 2), 32'd1);
        check("R2 side lines", {29'd0, ack_lo_n, ack_hi_n, lerr_n}, 32'd7);
        check("R4 low lanes", {8'd0, rdata[23:0]}, 32'd0);
        got = rdata[31:24];
        as_n = 1'b1;
        @(negedge clk);
        check("R3 ack release", {31'd0, ack_byte_n}, 32'd1);
        check("R4 rdata idle", rdata, 32'd0);
        sel_n = 1'b1;
        @(negedge clk);
    endtask

    // {rd, addr, siz, wdata byte, expected read byte}
    localparam logic [22:0] VEC [12] = '{
        {1'b1, 3'd1, 3'd1, 8'h00, 8'h00},   // R6 idle busy 0
        {1'b0, 3'd1, 3'd1, 8'h40, 8'h00},   // R5 enable
        {1'b1, 3'd1, 3'd1, 8'h00, 8'h40},   // R5 read back
        {1'b1, 3'd3, 3'd1, 8'h00, 8'h00},   // R7 not ready
        {1'b0, 3'd4, 3'd1, 8'hA5, 8'h00},   // R8 write
        {1'b1, 3'd4, 3'd1, 8'h00, 8'hA5},   // R8 read back
        {1'b1, 3'd5, 3'd1, 8'h00, 8'h00},   // R9 undecoded
        {1'b1, 3'd1, 3'd2, 8'h00, 8'h00},   // R9 bad size read
        {1'b0, 3'd1, 3'd2, 8'h00, 8'h00},   // R9 bad size write
        {1'b1, 3'd1, 3'd1, 8'h00, 8'h40},   // R9 enable unchanged
        {1'b0, 3'd7, 3'd1, 8'hFF, 8'h00},   // R9 undecoded write
        {1'b1, 3'd0, 3'd1, 8'h00, 8'h00}    // R6 tx data reset value
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 11:      return "R6";
            1, 2:       return "R5";
            3:          return "R7";
            4, 5:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    initial begin
        logic [7:0] got;
        logic [22:0] v;
        int polls;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 ack in reset", {28'd0, ack_byte_n, ack_lo_n, ack_hi_n, lerr_n}, 32'hF);
        check("R1 rdata in reset", rdata, 32'd0);
        check("R1 flags in reset", {29'd0, tx_en, tx_strobe, ser_strobe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", {31'd0, ack_byte_n}, 32'd1);

        for (int i = 0; i < 12; i++) begin
            v = VEC[i];
            bus(v[22], v[21:19], v[18:16], v[15:8], got);
            if (v[22]) check({vec_req(i), " vector read"}, {24'd0, got}, {24'd0, v[7:0]});
        end
        check("R5 tx_en pin", {31'd0, tx_en}, 32'd1);
        check("R8 ser strobes", 32'(ser_cnt), 32'd1);
        check("R8 ser byte", {24'd0, ser_byte}, 32'hA5);
        check("R9 no tx strobe", 32'(tx_cnt), 32'd0);

        // R9: bad-size write to transmit data has no effect
        bus(1'b0, 3'd0, 3'd4, 8'h77, got);
        check("R9 bad size tx write", 32'(tx_cnt), 32'd0);
        bus(1'b1, 3'd1, 3'd1, 8'h00, got);
        check("R9 busy untouched", {24'd0, got}, 32'h40);

        // R6 and R7: loopback of 0x55
        bus(1'b0, 3'd0, 3'd1, 8'h55, got);
        check("R6 tx strobe", 32'(tx_cnt), 32'd1);
        check("R6 tx byte", {24'd0, tx_byte}, 32'h55);
        bus(1'b1, 3'd1, 3'd1, 8'h00, got);
        check("R6 busy set", {24'd0, got}, 32'hC0);
        polls = 0;
        got = 8'h00;
        while (polls < 100 && got[7] !== 1'b1) begin
            bus(1'b1, 3'd3, 3'd1, 8'h00, got);
            polls = polls + 1;
        end
        check("R7 ready", {24'd0, got}, 32'h80);
        bus(1'b1, 3'd2, 3'd1, 8'h00, got);
        check("R7 rx data", {24'd0, got}, 32'h55);
        bus(1'b1, 3'd3, 3'd1, 8'h00, got);
        check("R7 ready cleared", {24'd0, got}, 32'h00);
        bus(1'b1, 3'd1, 3'd1, 8'h00, got);
        check("R6 busy cleared", {24'd0, got}, 32'h40);
        bus(1'b1, 3'd0, 3'd1, 8'h00, got);
        check("R6 tx data read", {24'd0, got}, 32'h55);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule